// File: doc/BRIEF.md
# Multi-Level Priority Interrupt Controller

This block keeps a bank of interrupt levels and decides which pending one the processor should take next. Every level has a four-state life cycle (disarmed, armed, waiting, active) and a separate enable bit. Levels come in groups of sixteen. Group 0 is the override class. Group 1 is the counter class and group 2 is the I/O class. Groups 3 and up are external groups. An external pulse or a software command can trigger a level. A request goes out only when the best enabled, uninhibited waiting level outranks every level that is already being serviced. Interrupt handlers can therefore nest.

Software drives the bank with masked group commands. A command names one group, an operation and a 16-bit mask. The processor answers a request with an acknowledge, which makes the presented level active. It ends the service with a return, which releases the highest active level. Apart from the override class, which always comes first, the order of the classes and groups in the chain is held in a small set of slot registers that software can rewrite.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every override level (vector 0..15) is armed and enabled. Every other level is disarmed and disabled. `irq_req` is 0 and `irq_vec` is 0.
- R2: A disarmed level ignores both an external pulse and a software trigger, and stays disarmed.
- R3: An armed level that sees `ext_trig[v]` becomes waiting. While it is the winning candidate, `irq_req` is 1 and `irq_vec` = group*16 + level number.
- R4: Override levels cannot be disarmed, disabled or inhibited; they return to armed after service. `class_inh[0]` masks the counter group, `class_inh[1]` masks the I/O group and `class_inh[2]` masks all external groups, regardless of the per-level enables.
- R5: `ack` while `irq_req` is high makes the presented level active. A request is raised only when the best candidate has higher priority than the highest active level.
- R6: Override levels beat all others. Inside a group, a lower level number wins.
- R7: A disabled waiting level stays pending but is not requested; enabling it again makes it requestable.
- R8: `order_we` writes group `order_grp` into chain slot `order_slot`. Slot 0 ranks highest, directly after the override class. The reset order is slot s = group s+1. A slot holding 0, or a value of 3+EXT_GROUPS or more, is empty. A group in no slot never requests and its active levels are not counted. If a group sits in two slots, the earlier slot counts.
- R9: `ret` releases the highest-priority active level. The level becomes armed if `ret_rearm`=1 and disarmed if `ret_rearm`=0. Override levels always become armed.
- R10: `cmd_op` codes, applied to the levels selected by `cmd_mask` in group `cmd_grp` when `cmd_valid`=1:
  - 0: disarm.
  - 1: arm and enable.
  - 2: arm and disable.
  - 3: enable.
  - 4: disable.
  - 5: load the enables from `cmd_data`.
  - 6: software trigger.
  - 7: no operation.
- R11: A trigger that reaches a waiting or active level is ignored. When a command and an external pulse reach the same level in the same cycle, only the command takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_trig | input | 16*(3+EXT_GROUPS) | One-cycle trigger pulse per level, bit = vector |
| cmd_valid | input | 1 | Group command strobe |
| cmd_grp | input | 3 | Target group of the command |
| cmd_op | input | 3 | Command code (R10) |
| cmd_mask | input | 16 | Levels of the group affected |
| cmd_data | input | 16 | Enable values for the load-enables command |
| class_inh | input | 3 | Class inhibits: counter, I/O, external |
| order_we | input | 1 | Chain slot write strobe |
| order_slot | input | 3 | Chain slot index |
| order_grp | input | 3 | Group placed in that slot |
| ack | input | 1 | Processor acknowledge of the presented vector |
| ret | input | 1 | Release the highest active level |
| ret_rearm | input | 1 | 1: released level is armed, 0: disarmed |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | $clog2(16*(3+EXT_GROUPS)) | Vector of the requesting level |

## Verification
A level in the wrong state appears at the request outputs one cycle after the edge that stored it. A waiting level that should have stayed armed raises a request. An active level that was not recorded lets a lower candidate through. A dropped pending bit silences the request after an enable. The bench uses these effects to detect hidden state. To find out whether a trigger was ignored, it arms or enables the level afterwards and checks that no request appears. To check which level a return released, it triggers both candidates afterwards and watches which vector is presented. A wrong chain rank shows up as the wrong vector or a missing request in the same cycle that the slot write lands.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int GRP_SZ = 16;
  localparam int ORDER_W = 21;   // up to seven 3-bit chain slots

  typedef enum logic [1:0] {
    LV_DISARMED = 2'd0,
    LV_ARMED    = 2'd1,
    LV_WAITING  = 2'd2,
    LV_ACTIVE   = 2'd3
  } lvl_state_e;

  typedef enum logic [2:0] {
    OP_DISARM  = 3'd0,
    OP_ARM_EN  = 3'd1,
    OP_ARM_DIS = 3'd2,
    OP_ENABLE  = 3'd3,
    OP_DISABLE = 3'd4,
    OP_LOAD_EN = 3'd5,
    OP_TRIGGER = 3'd6,
    OP_NOP     = 3'd7
  } grp_op_e;

  // Rank of a group in the chain: 0 = override, s+1 = slot s, 7 = not in chain.
  function automatic logic [2:0] chain_rank(input logic [ORDER_W-1:0] order,
                                            input int unsigned nslot,
                                            input logic [2:0] grp);
    logic [2:0] r;
    r = 3'd7;
    if (grp == 3'd0) return 3'd0;
    for (int s = 6; s >= 0; s--)
      if (s < int'(nslot) && order[s*3 +: 3] == grp) r = 3'(s + 1);
    return r;
  endfunction

  // Which class inhibit covers a non-override group.
  function automatic logic [1:0] inh_index(input logic [2:0] grp);
    if (grp == 3'd1) return 2'd0;
    if (grp == 3'd2) return 2'd1;
    return 2'd2;
  endfunction
endpackage

// File: rtl/pic_chain_order.sv
module pic_chain_order
  import pic_pkg::*;
#(
  parameter int NSLOT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [2:0]         slot,
  input  logic [2:0]         grp,
  output logic [ORDER_W-1:0] order
);
  for (genvar s = 0; s < 7; s++) begin : g_slot
    if (s < NSLOT) begin : g_used
      logic [2:0] val_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                        val_q <= 3'(s + 1);
        else if (we && slot == 3'(s))      val_q <= grp;
      end
      assign order[s*3 +: 3] = val_q;
    end else begin : g_unused
      assign order[s*3 +: 3] = 3'd0;
    end
  end
endmodule

// File: rtl/pic_level_bank.sv
module pic_level_bank
  import pic_pkg::*;
#(
  parameter int NL = 112
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] cmd_hit,
  input  logic [2:0]    cmd_op,
  input  logic [NL-1:0] cmd_bit,
  input  logic [NL-1:0] ret_hit,
  input  logic          ret_rearm,
  input  logic [NL-1:0] ack_hit,
  input  logic [NL-1:0] trig,
  output logic [NL-1:0] lv_wait,
  output logic [NL-1:0] lv_act,
  output logic [NL-1:0] lv_dis,
  output logic [NL-1:0] lv_en
);
  for (genvar i = 0; i < NL; i++) begin : g_lvl
    localparam bit IS_OVR = (i < GRP_SZ);
    lvl_state_e st_q;
    logic       en_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q <= IS_OVR ? LV_ARMED : LV_DISARMED;
        en_q <= IS_OVR;
      end else if (cmd_hit[i]) begin
        case (grp_op_e'(cmd_op))
          OP_DISARM:  if (!IS_OVR) st_q <= LV_DISARMED;
          OP_ARM_EN:  begin st_q <= LV_ARMED; en_q <= 1'b1; end
          OP_ARM_DIS: begin st_q <= LV_ARMED; if (!IS_OVR) en_q <= 1'b0; end
          OP_ENABLE:  en_q <= 1'b1;
          OP_DISABLE: if (!IS_OVR) en_q <= 1'b0;
          OP_LOAD_EN: if (!IS_OVR) en_q <= cmd_bit[i];
          OP_TRIGGER: if (st_q == LV_ARMED) st_q <= LV_WAITING;
          default: ;
        endcase
      end else if (ret_hit[i]) begin
        st_q <= (ret_rearm || IS_OVR) ? LV_ARMED : LV_DISARMED;
      end else if (ack_hit[i]) begin
        st_q <= LV_ACTIVE;
      end else if (trig[i] && st_q == LV_ARMED) begin
        st_q <= LV_WAITING;
      end
    end

    assign lv_wait[i] = (st_q == LV_WAITING);
    assign lv_act[i]  = (st_q == LV_ACTIVE);
    assign lv_dis[i]  = (st_q == LV_DISARMED);
    assign lv_en[i]   = en_q;
  end
endmodule

// File: rtl/pic_chain_arb.sv
module pic_chain_arb
  import pic_pkg::*;
#(
  parameter int NL    = 112,
  parameter int NSLOT = 6,
  parameter int VW    = 7
) (
  input  logic [NL-1:0]      cand,
  input  logic [NL-1:0]      act,
  input  logic [ORDER_W-1:0] order,
  output logic               cand_ok,
  output logic [VW-1:0]      cand_idx,
  output logic [6:0]         cand_key,
  output logic               act_ok,
  output logic [VW-1:0]      act_idx,
  output logic [6:0]         act_key
);
  // Key = {chain rank, level number}; a smaller key wins.
  always_comb begin
    cand_ok = 1'b0; cand_idx = '0; cand_key = '1;
    act_ok  = 1'b0; act_idx  = '0; act_key  = '1;
    for (int i = 0; i < NL; i++) begin
      logic [2:0] rk;
      logic [6:0] key;
      rk  = chain_rank(order, NSLOT, 3'(i / GRP_SZ));
      key = {rk, 4'(i % GRP_SZ)};
      if (rk != 3'd7) begin
        if (cand[i] && (!cand_ok || key < cand_key)) begin
          cand_ok = 1'b1; cand_idx = VW'(i); cand_key = key;
        end
        if (act[i] && (!act_ok || key < act_key)) begin
          act_ok = 1'b1; act_idx = VW'(i); act_key = key;
        end
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter  int EXT_GROUPS = 4,
  localparam int NG    = 3 + EXT_GROUPS,
  localparam int NL    = NG * GRP_SZ,
  localparam int VW    = $clog2(NL),
  localparam int NSLOT = NG - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] ext_trig,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_grp,
  input  logic [2:0]    cmd_op,
  input  logic [15:0]   cmd_mask,
  input  logic [15:0]   cmd_data,
  input  logic [2:0]    class_inh,
  input  logic          order_we,
  input  logic [2:0]    order_slot,
  input  logic [2:0]    order_grp,
  input  logic          ack,
  input  logic          ret,
  input  logic          ret_rearm,
  output logic          irq_req,
  output logic [VW-1:0] irq_vec
);
  logic [NL-1:0] cmd_hit, cmd_bit, ret_hit, ack_hit, lv_inh, cand;
  logic [NL-1:0] lv_wait, lv_act, lv_dis, lv_en;
  logic [ORDER_W-1:0] order;
  logic          cand_ok, act_ok;
  logic [VW-1:0] cand_idx, act_idx;
  logic [6:0]    cand_key, act_key;
  logic          win;

  for (genvar i = 0; i < NL; i++) begin : g_hit
    localparam int G = i / GRP_SZ;
    localparam int B = i % GRP_SZ;
    assign cmd_hit[i] = cmd_valid && cmd_grp == 3'(G) && cmd_mask[B];
    assign cmd_bit[i] = cmd_data[B];
    assign ret_hit[i] = ret && act_ok && act_idx == VW'(i);
    assign ack_hit[i] = ack && win && cand_idx == VW'(i);
    if (G == 0) begin : g_ovr
      assign lv_inh[i] = 1'b0;
    end else begin : g_cls
      assign lv_inh[i] = class_inh[inh_index(3'(G))];
    end
  end

  assign cand = lv_wait & lv_en & ~lv_inh;

  pic_chain_order #(.NSLOT(NSLOT)) order_i (
    .clk(clk), .rst_n(rst_n), .we(order_we), .slot(order_slot),
    .grp(order_grp), .order(order)
  );

  pic_level_bank #(.NL(NL)) bank_i (
    .clk(clk), .rst_n(rst_n), .cmd_hit(cmd_hit), .cmd_op(cmd_op),
    .cmd_bit(cmd_bit), .ret_hit(ret_hit), .ret_rearm(ret_rearm),
    .ack_hit(ack_hit), .trig(ext_trig), .lv_wait(lv_wait),
    .lv_act(lv_act), .lv_dis(lv_dis), .lv_en(lv_en)
  );

  pic_chain_arb #(.NL(NL), .NSLOT(NSLOT), .VW(VW)) arb_i (
    .cand(cand), .act(lv_act), .order(order),
    .cand_ok(cand_ok), .cand_idx(cand_idx), .cand_key(cand_key),
    .act_ok(act_ok), .act_idx(act_idx), .act_key(act_key)
  );

  assign win     = cand_ok && (!act_ok || cand_key < act_key);
  assign irq_req = win;
  assign irq_vec = win ? cand_idx : '0;
endmodule

// File: rtl/pic_checker.sv
module pic_checker
  import pic_pkg::*;
#(
  parameter int NL = 112,
  parameter int VW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic          ret,
  input logic          cmd_valid,
  input logic [2:0]    class_inh,
  input logic          irq_req,
  input logic [VW-1:0] irq_vec,
  input logic [NL-1:0] lv_wait,
  input logic [NL-1:0] lv_act,
  input logic [NL-1:0] lv_dis,
  input logic [NL-1:0] lv_en
);
  logic [2:0] vec_grp;
  assign vec_grp = 3'(irq_vec / VW'(GRP_SZ));

  assert_ack_makes_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && !cmd_valid) |=> lv_act[$past(irq_vec)]);

  assert_req_is_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (lv_wait[irq_vec] && lv_en[irq_vec]));

  assert_inhibit_masks_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && vec_grp != 3'd0) |-> !class_inh[inh_index(vec_grp)]);

  assert_override_stays_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lv_dis[GRP_SZ-1:0] == '0) && (&lv_en[GRP_SZ-1:0]));

  assert_ret_frees_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !ack && !cmd_valid && |lv_act) |=>
      ($countones(lv_act) + 1 == $countones($past(lv_act))));

  assert_no_pending_no_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lv_wait == '0) |-> !irq_req);
endmodule

bind prio_irq_ctrl pic_checker #(.NL(NL), .VW(VW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ack(ack), .ret(ret), .cmd_valid(cmd_valid),
  .class_inh(class_inh), .irq_req(irq_req), .irq_vec(irq_vec),
  .lv_wait(lv_wait), .lv_act(lv_act), .lv_dis(lv_dis), .lv_en(lv_en)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int NL = 112;
  localparam int VW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] ext_trig = '0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_grp = '0, cmd_op = '0;
  logic [15:0]   cmd_mask = '0, cmd_data = '0;
  logic [2:0]    class_inh = '0;
  logic          order_we = 1'b0;
  logic [2:0]    order_slot = '0, order_grp = '0;
  logic          ack = 1'b0, ret = 1'b0, ret_rearm = 1'b0;
  logic          irq_req;
  logic [VW-1:0] irq_vec;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit    q_req[$];
  int    q_vec[$];
  string q_tag[$];

  always #2 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ext_trig(ext_trig), .cmd_valid(cmd_valid),
    .cmd_grp(cmd_grp), .cmd_op(cmd_op), .cmd_mask(cmd_mask), .cmd_data(cmd_data),
    .class_inh(class_inh), .order_we(order_we), .order_slot(order_slot),
    .order_grp(order_grp), .ack(ack), .ret(ret), .ret_rearm(ret_rearm),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  // Monitor: pops one expected item per falling edge and compares.
  initial forever begin
    @(negedge clk);
    #1;
    if (q_req.size() > 0) begin
      bit    er;
      int    ev;
      string et;
      er = q_req.pop_front();
      ev = q_vec.pop_front();
      et = q_tag.pop_front();
      total++;
      if (irq_req !== er || int'(irq_vec) != ev) begin
        bad++;
        $display("FAIL %s: req=%0b vec=%0d expected req=%0b vec=%0d",
                 et, irq_req, irq_vec, er, ev);
      end
    end
  end

  task automatic expect_out(input string tag, input bit r, input int v);
    q_req.push_back(r);
    q_vec.push_back(r ? v : 0);
    q_tag.push_back(tag);
    while (q_req.size() != 0) @(negedge clk);
    #2;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    ext_trig = '0; cmd_valid = 1'b0; order_we = 1'b0;
    ack = 1'b0; ret = 1'b0;
  endtask

  task automatic do_cmd(input int g, input int op, input logic [15:0] m,
                        input logic [15:0] d);
    cmd_valid = 1'b1; cmd_grp = 3'(g); cmd_op = 3'(op);
    cmd_mask = m; cmd_data = d;
    tick();
  endtask

  task automatic do_trig(input int v);
    ext_trig[v] = 1'b1;
    tick();
  endtask

  task automatic do_ack();
    ack = 1'b1;
    tick();
  endtask

  task automatic do_ret(input bit rearm);
    ret = 1'b1; ret_rearm = rearm;
    tick();
  endtask

  task automatic do_order(input int s, input int g);
    order_we = 1'b1; order_slot = 3'(s); order_grp = 3'(g);
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_out("R1 reset idle", 0, 0);

    // R2: pulse on a disarmed counter level, then arm it: nothing pending
    do_trig(20);
    do_cmd(1, 1, 16'h0010, 16'h0);
    expect_out("R2 disarmed ignores pulse", 0, 0);
    do_trig(20);
    expect_out("R3 armed level requests", 1, 20);
    do_trig(3);
    expect_out("R6 override outranks counter", 1, 3);
    do_ack();
    expect_out("R5 lower candidate held off by active", 0, 0);
    do_ret(1'b0);
    expect_out("R9 return frees override", 1, 20);
    do_trig(3);
    expect_out("R4 override rearmed despite rearm=0", 1, 3);
    do_ack();
    do_ret(1'b1);
    expect_out("R9 back to counter level", 1, 20);

    // R7: pending kept while disabled
    do_cmd(1, 4, 16'h0010, 16'h0);
    expect_out("R7 disabled level not requested", 0, 0);
    do_cmd(1, 3, 16'h0010, 16'h0);
    expect_out("R7 pending survives disable", 1, 20);
    class_inh = 3'b001;
    expect_out("R4 counter class inhibited", 0, 0);
    class_inh = 3'b000;
    expect_out("R4 inhibit released", 1, 20);

    // R8: chain reorder lets I/O nest above counter
    do_ack();
    do_cmd(2, 1, 16'h0001, 16'h0);
    do_cmd(2, 6, 16'h0001, 16'h0);
    expect_out("R5 I/O below active counter", 0, 0);
    do_order(0, 2);
    do_order(1, 1);
    expect_out("R8 I/O moved ahead of counter", 1, 32);
    do_ack();
    expect_out("R5 nested active", 0, 0);
    do_ret(1'b1);
    expect_out("R9 highest active released first", 0, 0);
    do_cmd(2, 6, 16'h0001, 16'h0);
    expect_out("R9 rearmed level triggers again", 1, 32);
    do_ret(1'b0);
    expect_out("R9 counter level released", 1, 32);
    do_ack();
    do_ret(1'b0);
    expect_out("R9 idle after disarming return", 0, 0);
    do_cmd(2, 6, 16'h0001, 16'h0);
    expect_out("R2 software trigger on disarmed", 0, 0);
    do_order(0, 1);
    do_order(1, 2);

    // R11: command wins over a same-cycle pulse
    do_cmd(3, 1, 16'h0001, 16'h0);
    ext_trig[48] = 1'b1;
    do_cmd(3, 0, 16'h0001, 16'h0);
    do_cmd(3, 1, 16'h0001, 16'h0);
    expect_out("R11 disarm beats pulse", 0, 0);
    ext_trig[48] = 1'b1;
    do_cmd(3, 3, 16'h0001, 16'h0);
    expect_out("R11 enable beats pulse", 0, 0);
    do_trig(48);
    expect_out("R3 external level requests", 1, 48);

    // R6: within a group the lower number wins
    do_cmd(3, 1, 16'h0004, 16'h0);
    do_trig(50);
    expect_out("R6 lower level number wins", 1, 48);
    do_ack();
    expect_out("R5 same group held off", 0, 0);
    do_trig(48);
    do_ret(1'b1);
    expect_out("R11 pulse on active ignored", 1, 50);
    do_ack();
    do_ret(1'b1);
    expect_out("R9 idle", 0, 0);

    // R8: empty slot removes a group
    do_order(2, 0);
    do_trig(48);
    expect_out("R8 group out of chain", 0, 0);
    do_order(2, 3);
    expect_out("R8 group restored", 1, 48);
    do_cmd(3, 5, 16'h0001, 16'h0000);
    expect_out("R10 load enables clear", 0, 0);
    do_cmd(3, 5, 16'h0001, 16'h0001);
    expect_out("R10 load enables set", 1, 48);
    do_cmd(4, 2, 16'h0020, 16'h0);
    do_trig(69);
    expect_out("R10 arm-disable leaves level quiet", 1, 48);
    do_cmd(3, 4, 16'h0001, 16'h0);
    expect_out("R10 disabled levels quiet", 0, 0);
    do_cmd(4, 3, 16'h0020, 16'h0);
    expect_out("R7 pending after arm-disable", 1, 69);

    // R4: override immune to disable, disarm and inhibit
    do_cmd(0, 4, 16'h0008, 16'h0);
    do_cmd(0, 0, 16'h0008, 16'h0);
    class_inh = 3'b111;
    do_trig(3);
    expect_out("R4 override ignores disable/disarm/inhibit", 1, 3);
    do_ack();
    do_ret(1'b0);
    class_inh = 3'b000;
    expect_out("R4 external resumes", 1, 69);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule